// File: doc/BRIEF.md
# Host Bus Register Address Decoder

This block sits between a host processor bus and the register set of a two-channel serial controller. It turns each host bus cycle into a register selection. A selection names the channel, the register index, the width (word or byte) and, for byte accesses, which byte. It works with multiplexed buses, where an address phase marked by an address strobe comes before the data phase. It also works with non-multiplexed buses, where the address is on the same lines as the strobe. It accepts separate read and write strobes, or a single data strobe with a read/not-write line.

After reset the block waits for its configuration. The first write cycle with chip select asserted is taken as the configuration word, whatever address it carries. If the address strobe is seen low before or during that write, the bus is treated as multiplexed from then on. The configuration chooses where the register address is taken from:
- the low-order address/data lines, in one of two bit layouts;
- a separate address field in the upper byte;
- an internal command/address register used as an indirect pointer. This register clears its own pointer field each time it is used.

Cycles with the data/control line high go straight to the transmit data register (on writes) or the receive data register (on reads). Each decoded access is shown on registered outputs with a one-cycle valid pulse.

Top module: `hbd_decoder`

## Requirements
- R1: After reset the configuration word, the configuration-done flag, the multiplexed-mode flag, the command/address register and the access-valid output are all zero.
- R2: The first write with `csel_n_i` low after reset loads `cfg_o` from `ad_i` at the write's trailing strobe edge and raises `cfg_done_o`. This holds whatever the address and data/control inputs are, and the write produces no access pulse. Later writes never change `cfg_o`.
- R3: If `addr_stb_n_i` is sampled low at any clock from reset release until the configuration is captured, `mux_mode_o` becomes 1 and stays 1. An address strobe after the configuration has no effect on the mode.
- R4: In multiplexed mode, `ad_i`, `chan_a_i` and `data_sel_i` are latched on the rising edge of `addr_stb_n_i`, and later changes do not affect the decode. In non-multiplexed mode they are sampled at the leading (falling) edge of the read, write or data strobe.
- R5: A leading edge of `rd_stb_n_i`, `wr_stb_n_i` or `dat_stb_n_i` with `csel_n_i` low, after configuration, gives exactly one `acc_valid_o` pulse of one cycle. The pulse appears on the clock edge that first samples the strobe low. `acc_write_o` is 1 for the write strobe, and for the data strobe with `rd_nwr_i` = 0.
- R6: In multiplexed mode, with the separate-address option not in force, the direct field is seven bits: `ad_i[6:0]` when config bit 0 is 1, or `ad_i[7:1]` when it is 0. Within that field, bits 5..1 are the index, bit 6 is byte/word and bit 0 is upper/lower.
- R7: When config bit 15 is 1 and config bit 2 is 0, the index comes from `ad_i[13:9]` and upper/lower from `ad_i[8]`, in both bus modes.
- R8: With data/control high, a write selects the transmit data register (`acc_kind_o` = 1) and a read selects the receive data register (`acc_kind_o` = 2). The index is the data index, upper/lower is 0, and the access is word-wide exactly when config bit 2 is 1.
- R9: An all-zero direct field, or non-multiplexed mode without the separate-address option, uses the command/address register. Its bits 5..1 give the index, bit 6 byte/word and bit 0 upper/lower. If its bits 6..0 were non-zero, they are cleared after the access. If they are all zero, the access targets the register itself (index 0).
- R10: A write that resolves to index 0 with kind register (`acc_kind_o` = 0) loads the command/address register at the trailing strobe edge. A word access loads all 16 bits from `ad_i`. A byte access loads `ad_i[7:0]` into the byte chosen by upper/lower.
- R11: `acc_word_o` is 1 only when config bit 2 is 1 and byte/word is 0. When `acc_word_o` is 0, `acc_upper_o` carries upper/lower (1 = upper byte). When `acc_word_o` is 1, `acc_upper_o` is 0.
- R12: An explicit index whose low four bits equal `DATA_NIB` (default 4'h8) selects the transmit data register on writes or the receive data register on reads. Index bit 4 is ignored and is output as 0.
- R13: A strobe with `csel_n_i` high produces no pulse and changes neither the configuration nor the command/address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ad_i | input | 16 | Address/data lines |
| chan_a_i | input | 1 | Channel select, 1 = channel A |
| data_sel_i | input | 1 | Data/control, 1 = implicit data register access |
| addr_stb_n_i | input | 1 | Address strobe, active low |
| rd_stb_n_i | input | 1 | Read strobe, active low |
| wr_stb_n_i | input | 1 | Write strobe, active low |
| dat_stb_n_i | input | 1 | Data strobe, active low |
| rd_nwr_i | input | 1 | Read/not-write qualifier for the data strobe |
| csel_n_i | input | 1 | Chip select, active low |
| acc_valid_o | output | 1 | One-cycle pulse marking a decoded access |
| acc_write_o | output | 1 | Access is a write |
| acc_chan_a_o | output | 1 | Decoded channel, 1 = channel A |
| acc_kind_o | output | 2 | 0 register, 1 transmit data, 2 receive data |
| acc_index_o | output | 5 | Register index |
| acc_word_o | output | 1 | 1 = 16-bit access |
| acc_upper_o | output | 1 | Upper byte select for byte accesses |
| cfg_o | output | 16 | Configuration word |
| cfg_done_o | output | 1 | Configuration has been captured |
| mux_mode_o | output | 1 | Multiplexed addressing detected |
| cmd_addr_o | output | 16 | Command/address register contents |

## Verification
The bench builds the decoder with `DATA_NIB` = 8, so random indices hit the data-register alias about one time in sixteen, with index bit 4 set and clear. Every combination of the shift, wide and separate-address bits is exercised, in both bus modes. Direct fields are biased toward zero so that the indirect path runs often. That path covers clearing after use and self-writes of the command/address register, as word and byte writes to either byte.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int BUS_W    = 16;
    localparam int IDX_W    = 5;
    localparam int CFG_SHR  = 0;
    localparam int CFG_WIDE = 2;
    localparam int CFG_SEP  = 15;

    typedef enum logic [1:0] {
        K_REG = 2'd0,
        K_TXD = 2'd1,
        K_RXD = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e        kind;
        logic [IDX_W-1:0] idx;
        logic             word;
        logic             upper;
        logic             use_cmd;
    } sel_t;

    // width and byte-lane choice: {word, upper}
    function automatic logic [1:0] size_pick(input logic wide, input logic bw, input logic ul);
        logic w;
        w = wide & ~bw;
        return {w, (w ? 1'b0 : ul)};
    endfunction

    function automatic acc_kind_e data_kind(input logic is_wr);
        return is_wr ? K_TXD : K_RXD;
    endfunction

endpackage

// File: rtl/hbd_strobe_edges.sv
module hbd_strobe_edges #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_n_i,
    output logic [N-1:0] lead_o,
    output logic [N-1:0] trail_o
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) prev_q[g] <= 1'b1;
            else     prev_q[g] <= lvl_n_i[g];
        end
        assign lead_o[g]  =  prev_q[g] & ~lvl_n_i[g];
        assign trail_o[g] = ~prev_q[g] &  lvl_n_i[g];
    end
endmodule

// File: rtl/hbd_cfg_capture.sv
module hbd_cfg_capture
    import hbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             astb_low_i,
    input  logic             lead_write_i,
    input  logic             trail_i,
    input  logic [BUS_W-1:0] ad_i,
    output logic [BUS_W-1:0] cfg_o,
    output logic             done_o,
    output logic             mux_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o  <= '0;
            done_o <= 1'b0;
            mux_o  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (!done_o && astb_low_i)   mux_o  <= 1'b1;
            if (!done_o && lead_write_i) pend_q <= 1'b1;
            if (pend_q && trail_i) begin
                cfg_o  <= ad_i;
                done_o <= 1'b1;
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hbd_addr_resolve.sv
module hbd_addr_resolve
    import hbd_pkg::*;
#(
    parameter logic [3:0] DATA_NIB = 4'h8
) (
    input  logic        shr_i,
    input  logic        wide_i,
    input  logic        sep_i,
    input  logic        mux_i,
    input  logic [6:0]  cmd_lo_i,
    input  logic        dsel_i,
    input  logic        wr_i,
    input  logic [13:0] ad_i,
    output sel_t        sel_o
);
    logic             sep_eff, have_dir;
    logic [6:0]       low_fld;
    logic [IDX_W-1:0] ix;
    logic             bw, ul;
    logic [1:0]       sz;

    assign sep_eff = sep_i & ~wide_i;
    assign low_fld = shr_i ? ad_i[6:0] : ad_i[7:1];

    always_comb begin
        have_dir = 1'b0;
        ix = cmd_lo_i[5:1];
        bw = cmd_lo_i[6];
        ul = cmd_lo_i[0];
        if (sep_eff) begin
            have_dir = |ad_i[13:8];
            if (have_dir) begin
                ix = ad_i[13:9];
                bw = 1'b1;
                ul = ad_i[8];
            end
        end else if (mux_i) begin
            have_dir = |low_fld;
            if (have_dir) begin
                ix = low_fld[5:1];
                bw = low_fld[6];
                ul = low_fld[0];
            end
        end
        sz = size_pick(wide_i, bw, ul);

        sel_o.use_cmd = 1'b0;
        if (dsel_i) begin
            sel_o.kind  = data_kind(wr_i);
            sel_o.idx   = {1'b0, DATA_NIB};
            sel_o.word  = wide_i;
            sel_o.upper = 1'b0;
        end else begin
            sel_o.use_cmd = ~have_dir & (|cmd_lo_i);
            sel_o.word    = sz[1];
            sel_o.upper   = sz[0];
            if (ix[3:0] == DATA_NIB) begin
                sel_o.kind = data_kind(wr_i);
                sel_o.idx  = {1'b0, ix[3:0]};
            end else begin
                sel_o.kind = K_REG;
                sel_o.idx  = ix;
            end
        end
    end
endmodule

// File: rtl/hbd_cmd_reg.sv
module hbd_cmd_reg
    import hbd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             wr_i,
    input  logic             word_i,
    input  logic             upper_i,
    input  logic [BUS_W-1:0] data_i,
    output logic [BUS_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (wr_i) begin
            if (word_i)       q_o        <= data_i;
            else if (upper_i) q_o[15:8]  <= data_i[7:0];
            else              q_o[7:0]   <= data_i[7:0];
        end else if (clr_i) begin
            q_o[6:0] <= '0;
        end
    end
endmodule

// File: rtl/hbd_decoder.sv
module hbd_decoder
    import hbd_pkg::*;
#(
    parameter logic [3:0] DATA_NIB = 4'h8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] ad_i,
    input  logic        chan_a_i,
    input  logic        data_sel_i,
    input  logic        addr_stb_n_i,
    input  logic        rd_stb_n_i,
    input  logic        wr_stb_n_i,
    input  logic        dat_stb_n_i,
    input  logic        rd_nwr_i,
    input  logic        csel_n_i,
    output logic        acc_valid_o,
    output logic        acc_write_o,
    output logic        acc_chan_a_o,
    output logic [1:0]  acc_kind_o,
    output logic [4:0]  acc_index_o,
    output logic        acc_word_o,
    output logic        acc_upper_o,
    output logic [15:0] cfg_o,
    output logic        cfg_done_o,
    output logic        mux_mode_o,
    output logic [15:0] cmd_addr_o
);
    localparam int NSTB = 4;   // 0 rd, 1 wr, 2 ds, 3 address strobe

    logic [NSTB-1:0] lead, trail;
    logic            ev, is_wr, acc_ev, trail_any;
    logic [15:0]     lat_ad;
    logic            lat_chan, lat_dsel;
    logic [15:0]     src_ad;
    logic            src_chan, src_dsel;
    sel_t            sel;
    logic            self_pend_q, self_word_q, self_upper_q;

    hbd_strobe_edges #(.N(NSTB)) edges_i (
        .clk(clk), .rst(rst),
        .lvl_n_i({addr_stb_n_i, dat_stb_n_i, wr_stb_n_i, rd_stb_n_i}),
        .lead_o(lead), .trail_o(trail)
    );

    assign ev        = (|lead[2:0]) & ~csel_n_i;
    assign is_wr     = lead[1] | (lead[2] & ~rd_nwr_i);
    assign acc_ev    = ev & cfg_done_o;
    assign trail_any = |trail[2:0];

    hbd_cfg_capture cfg_i (
        .clk(clk), .rst(rst),
        .astb_low_i(~addr_stb_n_i),
        .lead_write_i(ev & is_wr),
        .trail_i(trail_any),
        .ad_i(ad_i),
        .cfg_o(cfg_o), .done_o(cfg_done_o), .mux_o(mux_mode_o)
    );

    // address phase capture for multiplexed buses
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_ad   <= '0;
            lat_chan <= 1'b0;
            lat_dsel <= 1'b0;
        end else if (trail[3]) begin
            lat_ad   <= ad_i;
            lat_chan <= chan_a_i;
            lat_dsel <= data_sel_i;
        end
    end

    assign src_ad   = mux_mode_o ? lat_ad   : ad_i;
    assign src_chan = mux_mode_o ? lat_chan : chan_a_i;
    assign src_dsel = mux_mode_o ? lat_dsel : data_sel_i;

    hbd_addr_resolve #(.DATA_NIB(DATA_NIB)) res_i (
        .shr_i(cfg_o[CFG_SHR]), .wide_i(cfg_o[CFG_WIDE]), .sep_i(cfg_o[CFG_SEP]),
        .mux_i(mux_mode_o), .cmd_lo_i(cmd_addr_o[6:0]),
        .dsel_i(src_dsel), .wr_i(is_wr), .ad_i(src_ad[13:0]),
        .sel_o(sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            self_pend_q  <= 1'b0;
            self_word_q  <= 1'b0;
            self_upper_q <= 1'b0;
        end else if (acc_ev) begin
            self_pend_q  <= is_wr && sel.kind == K_REG && sel.idx == '0;
            self_word_q  <= sel.word;
            self_upper_q <= sel.upper;
        end else if (trail_any) begin
            self_pend_q  <= 1'b0;
        end
    end

    hbd_cmd_reg cmd_i (
        .clk(clk), .rst(rst),
        .clr_i(acc_ev & sel.use_cmd),
        .wr_i(self_pend_q & trail_any),
        .word_i(self_word_q), .upper_i(self_upper_q),
        .data_i(ad_i),
        .q_o(cmd_addr_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid_o  <= 1'b0;
            acc_write_o  <= 1'b0;
            acc_chan_a_o <= 1'b0;
            acc_kind_o   <= 2'd0;
            acc_index_o  <= '0;
            acc_word_o   <= 1'b0;
            acc_upper_o  <= 1'b0;
        end else begin
            acc_valid_o <= acc_ev;
            if (acc_ev) begin
                acc_write_o  <= is_wr;
                acc_chan_a_o <= src_chan;
                acc_kind_o   <= sel.kind;
                acc_index_o  <= sel.idx;
                acc_word_o   <= sel.word;
                acc_upper_o  <= sel.upper;
            end
        end
    end
endmodule

// File: rtl/hbd_decoder_chk.sv
module hbd_decoder_chk #(
    parameter logic [3:0] DATA_NIB = 4'h8
) (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid_o,
    input logic        acc_write_o,
    input logic [1:0]  acc_kind_o,
    input logic [4:0]  acc_index_o,
    input logic        acc_word_o,
    input logic        acc_upper_o,
    input logic [15:0] cfg_o,
    input logic        cfg_done_o,
    input logic        mux_mode_o
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!acc_valid_o && cfg_o == 16'h0 && !cfg_done_o && !mux_mode_o));

    p_cfg_first_r2: assert property (@(posedge clk) disable iff (rst)
        acc_valid_o |-> cfg_done_o);

    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_done_o |=> (cfg_done_o && $stable(cfg_o)));

    p_mux_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        mux_mode_o |=> mux_mode_o);

    p_mux_locked_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_done_o && !mux_mode_o) |=> !mux_mode_o);

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        acc_valid_o |=> !acc_valid_o);

    p_data_dir_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_o && acc_kind_o != 2'd0) |-> (acc_write_o == (acc_kind_o == 2'd1)));

    p_narrow_bus_r11: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_o && !cfg_o[2]) |-> !acc_word_o);

    p_word_lane_r11: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_o && acc_word_o) |-> !acc_upper_o);

    p_data_index_r12: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_o && acc_kind_o != 2'd0) |-> (acc_index_o == {1'b0, DATA_NIB}));
endmodule

bind hbd_decoder hbd_decoder_chk #(.DATA_NIB(DATA_NIB)) chk_i (.*);

// File: tb/hbd_decoder_tb_top.sv
module hbd_decoder_tb_top;
    localparam int         CLK_PERIOD = 10;
    localparam logic [3:0] NIB        = 4'h8;
    localparam int         LIMIT      = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] ad = '0;
    logic        chan_a = 1'b0, dsel = 1'b0;
    logic        astb_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ds_n = 1'b1, rnw = 1'b1, cs_n = 1'b1;
    logic        acc_valid, acc_write, acc_chan;
    logic [1:0]  acc_kind;
    logic [4:0]  acc_index;
    logic        acc_word, acc_upper;
    logic [15:0] cfg, cmd;
    logic        cfg_done, mux_mode;

    int checks = 0, errors = 0, pulses = 0;
    bit finished = 0;
    logic [15:0] m_cfg = '0, m_cmd = '0;
    bit          m_mux = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (acc_valid) pulses++;

    hbd_decoder #(.DATA_NIB(NIB)) dut_i (
        .clk(clk), .rst(rst), .ad_i(ad), .chan_a_i(chan_a), .data_sel_i(dsel),
        .addr_stb_n_i(astb_n), .rd_stb_n_i(rd_n), .wr_stb_n_i(wr_n), .dat_stb_n_i(ds_n),
        .rd_nwr_i(rnw), .csel_n_i(cs_n),
        .acc_valid_o(acc_valid), .acc_write_o(acc_write), .acc_chan_a_o(acc_chan),
        .acc_kind_o(acc_kind), .acc_index_o(acc_index), .acc_word_o(acc_word),
        .acc_upper_o(acc_upper), .cfg_o(cfg), .cfg_done_o(cfg_done),
        .mux_mode_o(mux_mode), .cmd_addr_o(cmd)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected decode: {kind[1:0], index[4:0], word, upper, uses_cmd}
    function automatic logic [9:0] expect_sel(input logic [15:0] c, input bit mx,
            input logic [15:0] ca, input bit ds, input bit w, input logic [15:0] a);
        bit wide = c[2];
        bit sep  = c[15] && !c[2];
        logic [6:0] f7 = c[0] ? a[6:0] : a[7:1];
        logic [4:0] ix;
        bit bw, ul, uc = 0, wd, up;
        logic [1:0] k = 2'd0;
        if (ds) return {(w ? 2'd1 : 2'd2), {1'b0, NIB}, wide, 1'b0, 1'b0};
        if (sep && a[13:8] != 6'd0) begin
            ix = a[13:9]; ul = a[8]; bw = 1;
        end else if (!sep && mx && f7 != 7'd0) begin
            ix = f7[5:1]; bw = f7[6]; ul = f7[0];
        end else begin
            ix = ca[5:1]; bw = ca[6]; ul = ca[0]; uc = (ca[6:0] != 7'd0);
        end
        wd = wide && !bw;
        up = wd ? 1'b0 : ul;
        if (ix[3:0] == NIB) begin k = w ? 2'd1 : 2'd2; ix[4] = 1'b0; end
        return {k, ix, wd, up, uc};
    endfunction

    task automatic do_reset();
        rst = 1'b1; m_cfg = '0; m_cmd = '0; m_mux = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [15:0] v, input bit with_as);
        if (with_as) begin
            ad = 16'h5a5a; astb_n = 1'b0; @(negedge clk); astb_n = 1'b1; @(negedge clk);
        end
        ad = v; dsel = 1'b1; cs_n = 1'b0; wr_n = 1'b0; @(negedge clk);
        wr_n = 1'b1; @(negedge clk);
        cs_n = 1'b1; dsel = 1'b0; @(negedge clk);
        m_cfg = v; m_mux = m_mux | with_as;
    endtask

    task automatic access(input bit w, input bit use_ds, input logic [15:0] a_lead,
                          input logic [15:0] a_trail, input bit ch, input bit ds,
                          input string req);
        logic [9:0] e;
        int p0;
        e = expect_sel(m_cfg, m_mux, m_cmd, ds, w, a_lead);
        if (m_mux) begin
            ad = a_lead; chan_a = ch; dsel = ds; astb_n = 1'b0; @(negedge clk);
            astb_n = 1'b1; @(negedge clk);
            ad = a_trail; chan_a = ~ch; dsel = ~ds;   // R4: changes after the latch
        end else begin
            ad = a_lead; chan_a = ch; dsel = ds;
        end
        p0 = pulses;
        cs_n = 1'b0; rnw = ~w;
        if (use_ds) ds_n = 1'b0; else if (w) wr_n = 1'b0; else rd_n = 1'b0;
        @(negedge clk);
        chk(acc_valid == 1'b1, "R5", "valid pulse", acc_valid, 1);
        chk(acc_write == w, "R5", "write flag", acc_write, w);
        chk(acc_chan == ch, "R4", "channel", acc_chan, ch);
        chk({acc_kind, acc_index, acc_word, acc_upper} == e[9:1], req, "decode",
            {acc_kind, acc_index, acc_word, acc_upper}, e[9:1]);
        ad = a_trail;
        ds_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        chk(acc_valid == 1'b0 && pulses == p0 + 1, "R5", "pulse count", pulses - p0, 1);
        cs_n = 1'b1; @(negedge clk);
        if (e[0]) m_cmd[6:0] = 7'd0;
        if (w && e[9:8] == 2'd0 && e[7:3] == 5'd0) begin
            if (e[2])      m_cmd = a_trail;
            else if (e[1]) m_cmd[15:8] = a_trail[7:0];
            else           m_cmd[7:0]  = a_trail[7:0];
        end
        chk(cmd == m_cmd, "R9", "command/address register (R10)", cmd, m_cmd);
        chk(cfg == m_cfg, "R2", "configuration unchanged", cfg, m_cfg);
    endtask

    function automatic logic [15:0] rnd_ad();
        logic [15:0] v = 16'($urandom);
        case ($urandom % 4)
            0: v[7:0]  = 8'h00;
            1: v[13:8] = 6'h00;
            default: ;
        endcase
        return v;
    endfunction

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", LIMIT, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int p0;
        void'($urandom(32'd2024));
        do_reset();
        // R1
        chk(cfg == 0 && !cfg_done && !mux_mode && cmd == 0 && !acc_valid, "R1", "reset state",
            {cfg, cfg_done, mux_mode}, 0);

        // R13: chip select high before configuration is ignored
        ad = 16'hffff; wr_n = 1'b0; @(negedge clk); wr_n = 1'b1; @(negedge clk);
        chk(!cfg_done && cfg == 0, "R13", "cs high write ignored", cfg, 0);

        // R2: first write loads cfg regardless of data/control
        p0 = pulses;
        cfg_write(16'h0004, 0);
        chk(cfg == 16'h0004 && cfg_done, "R2", "config captured", cfg, 16'h0004);
        chk(pulses == p0, "R2", "no pulse on config write", pulses - p0, 0);
        chk(!mux_mode, "R3", "non-multiplexed", mux_mode, 0);
        // R3: address strobe after configuration does not switch mode
        astb_n = 1'b0; @(negedge clk); astb_n = 1'b1; @(negedge clk);
        chk(!mux_mode, "R3", "late strobe ignored", mux_mode, 0);

        // R9: indirect self access, then pointer use and clearing; R10 word write
        access(1, 0, 16'h0000, 16'h0046, 1, 0, "R10");   // loads 0x0046: idx 3, byte, lower
        access(0, 1, 16'h1234, 16'h0000, 0, 0, "R9");    // uses pointer, clears
        access(0, 0, 16'h0000, 16'h0000, 1, 1, "R8");    // implicit receive, word
        access(1, 1, 16'h0000, 16'h0000, 0, 1, "R8");    // implicit transmit
        // R12: pointer with index 0x18 aliases the data register
        access(1, 0, 16'h0000, 16'h0030, 0, 0, "R10");
        access(1, 0, 16'h0000, 16'h0000, 1, 0, "R12");

        // R13 after configuration
        p0 = pulses; m_cmd = cmd;
        ad = 16'h0000; rd_n = 1'b0; @(negedge clk); rd_n = 1'b1; @(negedge clk);
        chk(pulses == p0 && cmd == m_cmd, "R13", "cs high access ignored", pulses - p0, 0);

        // R3/R6/R7: multiplexed, shift layouts and separate-address field
        do_reset();
        cfg_write(16'h0005, 1);
        chk(mux_mode, "R3", "multiplexed detected", mux_mode, 1);
        access(0, 0, 16'h0013, 16'hffff, 1, 0, "R6");
        access(1, 0, 16'h0042, 16'hffff, 0, 0, "R11");
        do_reset();
        cfg_write(16'h8000, 0);
        access(0, 0, 16'h2b00, 16'h0000, 1, 0, "R7");
        access(0, 0, 16'h1100, 16'h0000, 0, 0, "R12");

        // random regression over all configurations and both modes
        for (int s = 0; s < 16; s++) begin
            logic [15:0] cv = '0;
            cv[0] = s[0]; cv[2] = s[1]; cv[15] = s[2];
            do_reset();
            cfg_write(cv, s[3]);
            chk(mux_mode == s[3], "R3", "mode detect", mux_mode, s[3]);
            for (int i = 0; i < 60; i++) begin
                bit w = 1'($urandom);
                bit d = ($urandom % 6) == 0;
                string rq = d ? "R8" : (cv[15] && !cv[2]) ? "R7" : s[3] ? "R6" : "R9";
                access(w, 1'($urandom), rnd_ad(), 16'($urandom), 1'($urandom), d, rq);
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule